// File: doc/BRIEF.md
# Bus-Hold Handshake Controller

This block decides who owns a shared external bus: the local bus controller or an outside master. The outside master asks for the bus with an active-low hold request. Once the hold protocol is enabled, the block waits for the local controller to reach a cycle boundary, which the controller reports as idle. At that point the block floats the local pin drivers and acknowledges the hold with an active-low signal.

While the outside master owns the bus, the block watches the local controller's pending-cycle flag. When a local cycle is pending, it raises an active-low bus request so the master knows that the local side wants the bus back. When the hold request goes away, the block drops the acknowledge and the bus request together. It keeps the drivers floating for one more clock, then returns the bus to the local controller.

The state machine has five states:
- `ST_LOCAL`: the local side owns the bus.
- `ST_WAIT_IDLE`: a hold is requested and the block waits for a cycle boundary.
- `ST_HELD`: the hold is granted and no local cycle is waiting.
- `ST_HELD_REQ`: the hold is granted and the bus request is raised.
- `ST_RELEASE`: a one-clock turnaround with the drivers still floating.

The transitions are:
- LOCAL→WAIT_IDLE: a request arrives while the controller is busy.
- LOCAL→HELD or LOCAL→HELD_REQ: a request arrives while the controller is idle. HELD_REQ is taken when a local cycle is pending.
- WAIT_IDLE→HELD or WAIT_IDLE→HELD_REQ: the controller becomes idle.
- WAIT_IDLE→LOCAL: the request is withdrawn or the protocol is disabled.
- HELD→HELD_REQ: a local cycle becomes pending.
- HELD→RELEASE and HELD_REQ→RELEASE: the request is removed or the protocol is disabled.
- RELEASE→LOCAL: always, on the next clock.

Top module: `bus_hold_ctrl`

## Requirements
- R1: During and after reset, `hold_ack_n` and `bus_req_n` are 1, `bus_float` is 0 and the local side owns the bus.
- R2: While `hold_en` is 0, the hold request is ignored: `hold_ack_n` and `bus_req_n` stay 1 and `bus_float` stays 0.
- R3: The hold request passes through a two-flop synchronizer. With the controller idle, `hold_ack_n` falls after the third rising edge following the fall of `hold_req_n`, and not before.
- R4: The hold is granted only on an edge where `bus_idle` is 1. While `bus_idle` is 0, `hold_ack_n` stays 1 and `bus_float` stays 0.
- R5: Whenever `hold_ack_n` is 0, `bus_float` is 1. The two change on the same edge at grant.
- R6: `bus_req_n` goes to 0 only while the hold is acknowledged and a local cycle is pending. It may fall on the same edge as `hold_ack_n` or on a later edge, never earlier.
- R7: Once `bus_req_n` is 0, it stays 0 until the synchronized hold request is removed, even if `cyc_pending` drops.
- R8: When the synchronized hold request is removed, `hold_ack_n` and `bus_req_n` rise on the same edge. `bus_float` stays 1 for exactly one more clock and then falls.
- R9: Clearing `hold_en` during a granted hold releases the bus with the same sequence as R8. The bus is not granted again until `hold_en` returns to 1.
- R10: `cyc_pending` outside a granted hold never asserts `bus_req_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hold_en | input | 1 | Enables the hold protocol |
| hold_req_n | input | 1 | Hold request from the outside master, active low, asynchronous |
| cyc_pending | input | 1 | The local controller has an external cycle waiting |
| bus_idle | input | 1 | The local controller is at a bus-cycle boundary |
| hold_ack_n | output | 1 | Hold acknowledge, active low |
| bus_req_n | output | 1 | Bus request back to the outside master, active low |
| bus_float | output | 1 | Tells the pin drivers to tristate the bus |

## Verification
The bench sweeps the grant over idle delays of zero to three clocks and over both pending settings, and predicts the exact acknowledge edge from the synchronizer depth plus the delay. Each corner case targets one kind of fault:
- A design that skipped a synchronizer stage, or granted during a busy cycle, would acknowledge early.
- A design that let the bus request lead the acknowledge, or drop when pending falls, is caught by checking every clock of the hold.
- A design that let the float drop together with the acknowledge, or held it for too long, is caught by the release checks.
- A design that kept or re-granted the hold after the enable was cleared is caught by the disable checks.

// File: rtl/bhc_pkg.sv
package bhc_pkg;

    // Handshake states; encoding is free, only the names matter.
    typedef enum logic [2:0] {
        ST_LOCAL     = 3'd0,
        ST_WAIT_IDLE = 3'd1,
        ST_HELD      = 3'd2,
        ST_HELD_REQ  = 3'd3,
        ST_RELEASE   = 3'd4
    } bhc_state_e;

    // Minimum synchronizer depth accepted by the block.
    localparam int BHC_MIN_SYNC = 2;

endpackage

// File: rtl/bhc_sync.sv
module bhc_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RESET_VAL}};
        end else begin
            chain <= {chain[LAST-1:0], d_async};
        end
    end

    assign q_sync = chain[LAST];

    // R3: the synchronized value follows the raw input exactly STAGES edges late (depth 2 default).
    a_r3_sync_lag: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(d_async, 2) == $past(d_async, 2)) && $past(rst_n, 2) |-> (q_sync == $past(d_async, 2)) || (STAGES != 2));

endmodule

// File: rtl/bhc_fsm.sv
module bhc_fsm
    import bhc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold_en,
    input  logic hold_act,
    input  logic cyc_pending,
    input  logic bus_idle,
    output logic hold_ack_n,
    output logic bus_req_n,
    output logic bus_float
);
    bhc_state_e state_q;
    bhc_state_e state_d;

    logic want_hold;
    assign want_hold = hold_en && hold_act;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOCAL;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCAL: begin
                if (want_hold) begin
                    if (!bus_idle)        state_d = ST_WAIT_IDLE;
                    else if (cyc_pending) state_d = ST_HELD_REQ;
                    else                  state_d = ST_HELD;
                end
            end
            ST_WAIT_IDLE: begin
                if (!want_hold)        state_d = ST_LOCAL;
                else if (bus_idle) begin
                    if (cyc_pending)   state_d = ST_HELD_REQ;
                    else               state_d = ST_HELD;
                end
            end
            ST_HELD: begin
                if (!want_hold)        state_d = ST_RELEASE;
                else if (cyc_pending)  state_d = ST_HELD_REQ;
            end
            ST_HELD_REQ: begin
                if (!want_hold)        state_d = ST_RELEASE;
            end
            ST_RELEASE: begin
                state_d = ST_LOCAL;
            end
            default: state_d = ST_LOCAL;
        endcase
    end

    // Output decode (Moore).
    always_comb begin
        hold_ack_n = 1'b1;
        bus_req_n  = 1'b1;
        bus_float  = 1'b0;
        unique case (state_q)
            ST_LOCAL, ST_WAIT_IDLE: begin
                bus_float = 1'b0;
            end
            ST_HELD: begin
                hold_ack_n = 1'b0;
                bus_float  = 1'b1;
            end
            ST_HELD_REQ: begin
                hold_ack_n = 1'b0;
                bus_req_n  = 1'b0;
                bus_float  = 1'b1;
            end
            ST_RELEASE: begin
                bus_float = 1'b1;
            end
            default: begin
                bus_float = 1'b0;
            end
        endcase
    end

    // R2: protocol disabled for two samples means no acknowledge.
    a_r2_disabled_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_en && $past(!hold_en)) |-> (hold_ack_n && bus_req_n));

    // R4: the drivers start floating only after an idle sample.
    a_r4_grant_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_float) |-> $past(bus_idle));

    // R5: acknowledge implies floating drivers.
    a_r5_ack_floats: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_ack_n |-> bus_float);

    // R6: bus request never leads the acknowledge.
    a_r6_req_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req_n |-> !hold_ack_n);

    // R10: a fresh bus request is always backed by a pending cycle.
    a_r10_req_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req_n) |-> $past(cyc_pending));

    // R7: the request persists while the hold is still wanted.
    a_r7_req_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_req_n && want_hold) |=> !bus_req_n);

    // R8: acknowledge and request rise together; float lingers one clock.
    a_r8_release_order: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack_n) |-> (bus_req_n && bus_float));

    a_r8_float_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack_n) |=> !bus_float);

endmodule

// File: rtl/bus_hold_ctrl.sv
module bus_hold_ctrl
    import bhc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_en,
    input  logic hold_req_n,
    input  logic cyc_pending,
    input  logic bus_idle,
    output logic hold_ack_n,
    output logic bus_req_n,
    output logic bus_float
);
    localparam int DEPTH = (SYNC_STAGES < BHC_MIN_SYNC) ? BHC_MIN_SYNC : SYNC_STAGES;

    logic hold_req_n_s;
    logic hold_act;

    bhc_sync #(
        .STAGES    (DEPTH),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (hold_req_n),
        .q_sync  (hold_req_n_s)
    );

    assign hold_act = ~hold_req_n_s;

    bhc_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold_en     (hold_en),
        .hold_act    (hold_act),
        .cyc_pending (cyc_pending),
        .bus_idle    (bus_idle),
        .hold_ack_n  (hold_ack_n),
        .bus_req_n   (bus_req_n),
        .bus_float   (bus_float)
    );

    // R1: outputs inactive while reset is held.
    always_comb begin
        if (!rst_n) begin
            a_r1_reset_idle: assert (hold_ack_n && bus_req_n && !bus_float);
        end
    end

endmodule

// File: tb/bus_hold_ctrl_tb.sv
module bus_hold_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n, hold_en, hold_req_n, cyc_pending, bus_idle;
    logic hold_ack_n, bus_req_n, bus_float;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    bus_hold_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .hold_en(hold_en), .hold_req_n(hold_req_n),
        .cyc_pending(cyc_pending), .bus_idle(bus_idle),
        .hold_ack_n(hold_ack_n), .bus_req_n(bus_req_n), .bus_float(bus_float)
    );

    // Compare {hold_ack_n, bus_req_n, bus_float} against expectation.
    task automatic chk(input string tag, input logic [2:0] exp);
        logic [2:0] act;
        act = {hold_ack_n, bus_req_n, bus_float};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: {ack_n,req_n,float} actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    localparam logic [2:0] O_LOCAL = 3'b110;
    localparam logic [2:0] O_HELD  = 3'b011;
    localparam logic [2:0] O_HREQ  = 3'b001;
    localparam logic [2:0] O_REL   = 3'b111;

    // Release sequence after hold_req_n rises at this negedge (R8).
    task automatic release_hold(input logic [2:0] held_out);
        hold_req_n = 1'b1;
        tick(); chk("R8 sync stage 1 still held", held_out);
        tick(); chk("R8 sync stage 2 still held", held_out);
        tick(); chk("R8 ack and req rise together, float kept", O_REL);
        tick(); chk("R8 float drops one clock later", O_LOCAL);
    endtask

    initial begin
        rst_n = 1'b0; hold_en = 1'b0; hold_req_n = 1'b1;
        cyc_pending = 1'b0; bus_idle = 1'b1;
        tick(); tick();
        chk("R1 outputs during reset", O_LOCAL);
        tick();
        rst_n = 1'b1;
        tick(); chk("R1 outputs after reset", O_LOCAL);

        // R2: protocol disabled, request and pending ignored.
        hold_req_n = 1'b0; cyc_pending = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(); chk("R2 disabled ignores hold", O_LOCAL);
        end
        hold_req_n = 1'b1; cyc_pending = 1'b0;
        tick(); tick(); tick();

        // R10: pending without hold never requests.
        hold_en = 1'b1; cyc_pending = 1'b1;
        for (int i = 0; i < 5; i++) begin
            tick(); chk("R10 pending outside hold", O_LOCAL);
        end
        cyc_pending = 1'b0;

        // Sweep idle delay w and pending-at-grant p (R3, R4, R5, R6, R7, R8).
        for (int w = 0; w < 4; w++) begin
            for (int p = 0; p < 2; p++) begin
                bus_idle    = (w == 0);
                cyc_pending = p[0];
                hold_req_n  = 1'b0;
                for (int k = 1; k <= 6; k++) begin
                    logic [2:0] e;
                    tick();
                    if (k >= 3 + w) e = p[0] ? O_HREQ : O_HELD;
                    else            e = O_LOCAL;
                    if (k < 3)      chk("R3 grant waits for synchronizer", e);
                    else if (k < 3 + w) chk("R4 no grant while busy", e);
                    else            chk("R5 R6 grant edge outputs", e);
                    if (k == 2 + w) bus_idle = 1'b1;
                end
                // R6: bus request later than acknowledge.
                cyc_pending = 1'b1;
                tick(); chk("R6 request follows pending during hold", O_HREQ);
                // R7: request sticky when pending drops.
                cyc_pending = 1'b0;
                for (int i = 0; i < 3; i++) begin
                    tick(); chk("R7 request held until release", O_HREQ);
                end
                release_hold(O_HREQ);
            end
        end

        // R8 from plain HELD (no request ever raised).
        cyc_pending = 1'b0; bus_idle = 1'b1; hold_req_n = 1'b0;
        tick(); tick(); tick(); chk("R8 setup held", O_HELD);
        release_hold(O_HELD);

        // R9: disable during hold.
        cyc_pending = 1'b1; hold_req_n = 1'b0;
        tick(); tick(); tick(); chk("R9 setup held with request", O_HREQ);
        hold_en = 1'b0;
        tick(); chk("R9 disable drops ack and req together", O_REL);
        tick(); chk("R9 float drops after turnaround", O_LOCAL);
        for (int i = 0; i < 4; i++) begin
            tick(); chk("R9 no regrant while disabled", O_LOCAL);
        end
        hold_en = 1'b1;
        tick(); chk("R9 regrant after enable", O_HREQ);
        release_hold(O_HREQ);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule